// File: doc/BRIEF.md
# Soft-Correlation Frame Synchronizer

The block sits after a demodulator that delivers one 3-bit soft decision per accepted input cycle. It slides a window over the most recent 24 decisions and scores the window against a fixed 24-bit sync pattern. The score sums signed soft values instead of counting matched hard bits, so weak but consistent decisions still add up to a detection at low signal-to-noise ratio. When the score reaches a threshold supplied on a port, the block captures the fixed number of soft values that follow. While it captures, it does not search for the pattern.

Captured values go into an internal buffer in the order they arrived. They leave on an AXI-Stream master, and TLAST marks the final value of each frame. The downstream consumer (deinterleaver and decoder) can stall the stream with TREADY low. Nothing is lost until the buffer is full. A frame value that arrives when the buffer is full is dropped, and a sticky overflow flag is raised.

Top module: `ssf_top`

## Requirements
- R1: While reset is held and right after it is released, `m_tvalid`, `ovf` and `in_frame` are 0.
- R2: Each soft code c is mapped to the signed value c − 2^(SOFT_W−1), so with 3 bits the codes 0..7 become −4..+3 and code 7 is the strongest '1'. The first value of the 24 received pairs with bit 23 of the sync word 0x02B8DB, which is sent MSB first. A value is added when its sync bit is 1 and subtracted when it is 0. Sync is declared on the accepted value that completes the window when the sum is ≥ the signed `sync_thr`, once at least 24 values have been accepted since reset.
- R3: A window whose score is one below `sync_thr` does not start a capture.
- R4: After sync, exactly FRAME_LEN further accepted values are emitted on `m_tdata`, in arrival order.
- R5: `m_tlast` is 1 on the FRAME_LEN-th value of a frame and 0 on every other value.
- R6: Cycles with `in_valid` low are ignored by both the correlator and the capture, whatever is on `in_soft`.
- R7: While a frame is being captured, a sync pattern inside the frame data is treated as data and does not restart or extend the frame.
- R8: The value accepted right after a frame's last value is already examined for sync, so a sync word that immediately follows a frame is detected.
- R9: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid`, `m_tdata` and `m_tlast` hold, and every value buffered during the stall is delivered later.
- R10: A frame value that arrives while the buffer holds DEPTH entries is dropped and sets `ovf`. `ovf` stays 1 until reset and is never set while space remains.
- R11: `in_frame` is 1 from the cycle after the sync-completing value until the cycle after the frame's last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Soft decision valid |
| in_soft | input | SOFT_W | Soft decision code (higher = more likely '1') |
| sync_thr | input | SCORE_W | Signed detection threshold |
| m_tvalid | output | 1 | Stream data valid |
| m_tready | input | 1 | Stream ready from the consumer |
| m_tdata | output | SOFT_W | Captured soft value |
| m_tlast | output | 1 | Last value of a frame |
| in_frame | output | 1 | Capture in progress |
| ovf | output | 1 | Sticky buffer overflow flag |

## Verification
The assertions watch several rules on every cycle:
- the stream output holds steady under back-pressure;
- `ovf` is sticky, and it only rises after a frame value met a full buffer;
- `in_frame` only changes on a cycle that accepted an input;
- the outputs are quiet during reset.

Other behaviour can only be shown by the scenarios, which compare what the block did against values the bench derives from the requirements:
- the correlation arithmetic and its threshold boundary;
- MSB-first pattern order;
- frame length and order;
- TLAST placement;
- suppression of detection inside a frame;
- back-to-back frames;
- which values survive an overflow.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_CAPT = 1'b1
  } ssf_state_e;
endpackage

// File: rtl/ssf_corr.sv
// Sliding soft correlator: scores the window formed by the current input
// and the previous SYNC_LEN-1 accepted values.
module ssf_corr #(
  parameter int SOFT_W   = 3,
  parameter int SYNC_LEN = 24,
  parameter logic [SYNC_LEN-1:0] SYNC_WORD = 24'h02B8DB,
  parameter int SCORE_W  = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [SOFT_W-1:0]         in_soft,
  output logic signed [SCORE_W-1:0] score_o,
  output logic                      primed_o
);
  localparam int HIST   = SYNC_LEN - 1;
  localparam int FILL_W = $clog2(SYNC_LEN);
  localparam logic signed [SCORE_W-1:0] MID = SCORE_W'(1 << (SOFT_W - 1));

  logic [SOFT_W-1:0] hist_q [HIST];
  logic [SOFT_W-1:0] hist_d [HIST];
  logic [SOFT_W-1:0] tap    [SYNC_LEN];
  logic [FILL_W-1:0] fill_q, fill_d;

  // tap[p] pairs with SYNC_WORD[p]; tap[0] is the newest value
  assign tap[0] = in_soft;
  generate
    for (genvar p = 1; p < SYNC_LEN; p++) begin : g_tap
      assign tap[p] = hist_q[p-1];
    end
  endgenerate

  always_comb begin
    hist_d[0] = in_soft;
    for (int i = 1; i < HIST; i++) hist_d[i] = hist_q[i-1];
    fill_d = (fill_q == FILL_W'(HIST)) ? fill_q : fill_q + FILL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HIST; i++) hist_q[i] <= '0;
      fill_q <= '0;
    end else if (in_valid) begin
      for (int i = 0; i < HIST; i++) hist_q[i] <= hist_d[i];
      fill_q <= fill_d;
    end
  end

  assign primed_o = (fill_q == FILL_W'(HIST));

  logic signed [SCORE_W-1:0] acc, term;
  always_comb begin
    acc  = '0;
    term = '0;
    for (int p = 0; p < SYNC_LEN; p++) begin
      term = $signed({{(SCORE_W-SOFT_W){1'b0}}, tap[p]}) - MID;
      if (SYNC_WORD[p]) acc = acc + term;
      else              acc = acc - term;
    end
    score_o = acc;
  end
endmodule

// File: rtl/ssf_ctrl.sv
// Hunt/capture sequencer: counts frame values and marks the last one.
module ssf_ctrl
  import ssf_pkg::*;
#(
  parameter int FRAME_LEN = 1072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic hit,
  output logic wr_en,
  output logic wr_last,
  output logic in_frame
);
  localparam int CW = $clog2(FRAME_LEN);

  ssf_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wr_en   = 1'b0;
    wr_last = 1'b0;
    case (state_q)
      ST_HUNT: begin
        if (in_valid && hit) begin
          state_d = ST_CAPT;
          cnt_d   = '0;
        end
      end
      ST_CAPT: begin
        if (in_valid) begin
          wr_en   = 1'b1;
          wr_last = (cnt_q == CW'(FRAME_LEN - 1));
          if (wr_last) state_d = ST_HUNT;
          else         cnt_d   = cnt_q + CW'(1);
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign in_frame = (state_q == ST_CAPT);
endmodule

// File: rtl/ssf_fifo.sv
// Frame buffer with a stream-side pop; writes are refused when full.
module ssf_fifo #(
  parameter int DW    = 4,
  parameter int DEPTH = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          full,
  output logic          pop_valid,
  input  logic          pop_ready,
  output logic [DW-1:0] pop_data
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wp_q, wp_d, rp_q, rp_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            wr_ok, rd_ok;

  assign full      = (cnt_q == CNTW'(DEPTH));
  assign pop_valid = (cnt_q != '0);
  assign pop_data  = mem[rp_q];
  assign wr_ok     = push && !full;
  assign rd_ok     = pop_valid && pop_ready;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    if (wr_ok) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
    if (rd_ok) rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    cnt_d = cnt_q + CNTW'(wr_ok) - CNTW'(rd_ok);
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ssf_top.sv
module ssf_top #(
  parameter int SOFT_W    = 3,
  parameter int SYNC_LEN  = 24,
  parameter logic [SYNC_LEN-1:0] SYNC_WORD = 24'h02B8DB,
  parameter int FRAME_LEN = 1072,
  parameter int DEPTH     = 2048,
  parameter int SCORE_W   = $clog2(SYNC_LEN * (1 << (SOFT_W - 1))) + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [SOFT_W-1:0]  in_soft,
  input  logic [SCORE_W-1:0] sync_thr,
  output logic               m_tvalid,
  input  logic               m_tready,
  output logic [SOFT_W-1:0]  m_tdata,
  output logic               m_tlast,
  output logic               in_frame,
  output logic               ovf
);
  logic signed [SCORE_W-1:0] score;
  logic primed, hit, wr_en, wr_last, fifo_full, ovf_q, ovf_d;
  logic [SOFT_W:0] pop_word;

  ssf_corr #(
    .SOFT_W(SOFT_W), .SYNC_LEN(SYNC_LEN),
    .SYNC_WORD(SYNC_WORD), .SCORE_W(SCORE_W)
  ) u_corr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soft(in_soft),
    .score_o(score), .primed_o(primed)
  );

  assign hit = primed && (score >= $signed(sync_thr));

  ssf_ctrl #(.FRAME_LEN(FRAME_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hit(hit),
    .wr_en(wr_en), .wr_last(wr_last), .in_frame(in_frame)
  );

  ssf_fifo #(.DW(SOFT_W + 1), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(wr_en),
    .push_data({wr_last, in_soft}), .full(fifo_full),
    .pop_valid(m_tvalid), .pop_ready(m_tready), .pop_data(pop_word)
  );

  assign m_tdata = pop_word[SOFT_W-1:0];
  assign m_tlast = pop_word[SOFT_W];

  always_comb ovf_d = ovf_q | (wr_en & fifo_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign ovf = ovf_q;
endmodule

// File: rtl/ssf_chk.sv
module ssf_chk #(
  parameter int SOFT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic [SOFT_W-1:0] m_tdata,
  input logic              m_tlast,
  input logic              in_frame,
  input logic              ovf,
  input logic              fifo_full
);
  // R1: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!m_tvalid && !ovf && !in_frame)
        else $error("R1 outputs active in reset");
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  p_ovf_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(fifo_full && in_valid && in_frame));

  p_frame_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> $past(in_valid));

  p_frame_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_frame) |-> $past(in_valid));
endmodule

bind ssf_top ssf_chk #(.SOFT_W(SOFT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
  .m_tlast(m_tlast), .in_frame(in_frame), .ovf(ovf), .fifo_full(fifo_full)
);

// File: tb/sim_ssf_top.sv
`timescale 1ns/1ps
module sim_ssf_top;
  localparam int SW = 3;
  localparam int FL = 32;
  localparam int DP = 40;
  localparam int SCW = 9;
  localparam logic [23:0] SYNC = 24'h02B8DB;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [SW-1:0] in_soft;
  logic [SCW-1:0] sync_thr;
  logic m_tvalid, m_tready, m_tlast, in_frame, ovf;
  logic [SW-1:0] m_tdata;

  always #2 clk = ~clk;

  ssf_top #(.SOFT_W(SW), .SYNC_LEN(24), .SYNC_WORD(SYNC), .FRAME_LEN(FL),
            .DEPTH(DP), .SCORE_W(SCW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soft(in_soft),
    .sync_thr(sync_thr), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tdata(m_tdata), .m_tlast(m_tlast), .in_frame(in_frame), .ovf(ovf)
  );

  int total = 0;
  int bad = 0;
  logic [SW-1:0] rx_d [256];
  logic          rx_l [256];
  int            rx_n = 0;
  logic [SW-1:0] ex_d [256];
  int            ex_n = 0;

  // stream monitor: samples between the driving negedge and the next posedge
  always begin
    @(negedge clk);
    #1;
    if (rst_n && m_tvalid && m_tready) begin
      if (rx_n < 256) begin
        rx_d[rx_n] = m_tdata;
        rx_l[rx_n] = m_tlast;
      end
      rx_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench-side score of a word sent MSB first with codes hi for 1 and lo for 0
  function automatic int corr(input logic [23:0] sent, input int hi, input int lo);
    int sum = 0;
    for (int k = 0; k < 24; k++) begin
      int s = (sent[23-k] ? hi : lo) - 4;
      sum += SYNC[23-k] ? s : -s;
    end
    return sum;
  endfunction

  task automatic push(input logic [SW-1:0] c);
    @(negedge clk);
    in_valid <= 1'b1;
    in_soft  <= c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid <= 1'b0;
      in_soft  <= 3'd7;
    end
  endtask

  task automatic send_word(input logic [23:0] w, input logic [SW-1:0] hi, input logic [SW-1:0] lo);
    for (int k = 23; k >= 0; k--) push(w[k] ? hi : lo);
  endtask

  task automatic clear_window();
    sync_thr = 9'd200;
    for (int i = 0; i < 24; i++) push(3'd4);
    idle(2);
  endtask

  task automatic send_frame(input bit gaps);
    for (int i = 0; i < FL; i++) begin
      logic [SW-1:0] v = SW'((i % 3) + 3);
      if (i == 5) v = 3'd0;
      if (i == 9) v = 3'd7;
      push(v);
      ex_d[ex_n] = v;
      ex_n++;
      if (gaps && (i % 7 == 3)) idle(2);
    end
  endtask

  task automatic cmp_rx(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      chk(rx_d[i] == ex_d[i], req, int'(rx_d[i]), int'(ex_d[i]));
      if (rx_d[i] != ex_d[i]) break;
    end
  endtask

  task automatic t_reset();
    idle(2);
    #1;
    chk(!m_tvalid, "R1 tvalid", int'(m_tvalid), 0);
    chk(!ovf, "R1 ovf", int'(ovf), 0);
    chk(!in_frame, "R1 in_frame", int'(in_frame), 0);
  endtask

  task automatic t_basic();
    int lasts = 0;
    rx_n = 0; ex_n = 0;
    sync_thr = SCW'(corr(SYNC, 7, 0));
    for (int i = 0; i < 4; i++) push(3'd4);
    send_word(SYNC, 3'd7, 3'd0);
    idle(1); #1;
    chk(in_frame, "R2 R11 sync detected", int'(in_frame), 1);
    send_frame(1'b1);
    idle(1); #1;
    chk(!in_frame, "R11 in_frame low after frame", int'(in_frame), 0);
    idle(6);
    chk(rx_n == FL, "R4 R6 frame length", rx_n, FL);
    cmp_rx(FL, "R4 order");
    for (int i = 0; i < FL; i++) if (rx_l[i]) lasts++;
    chk(lasts == 1 && rx_l[FL-1], "R5 tlast placement", lasts, 1);
  endtask

  task automatic t_threshold();
    int ws = corr(SYNC, 5, 3);
    rx_n = 0; ex_n = 0;
    clear_window();
    sync_thr = SCW'(ws + 1);
    send_word(SYNC, 3'd5, 3'd3);
    idle(2); #1;
    chk(!in_frame && rx_n == 0, "R3 below threshold", int'(in_frame), 0);
    clear_window();
    sync_thr = SCW'(corr(SYNC, 7, 0));
    send_word({<<{SYNC}}, 3'd7, 3'd0);
    idle(2); #1;
    chk(!in_frame, "R2 reversed order not detected", int'(in_frame), 0);
    clear_window();
    sync_thr = SCW'(ws);
    send_word(SYNC, 3'd5, 3'd3);
    idle(1); #1;
    chk(in_frame, "R2 weak pattern at threshold", int'(in_frame), 1);
    send_frame(1'b0);
    idle(6);
    chk(rx_n == FL, "R2 frame after weak sync", rx_n, FL);
  endtask

  task automatic t_suppress();
    rx_n = 0; ex_n = 0;
    clear_window();
    sync_thr = SCW'(corr(SYNC, 7, 0));
    send_word(SYNC, 3'd7, 3'd0);
    for (int k = 23; k >= 0; k--) begin
      push(SYNC[k] ? 3'd7 : 3'd0);
      ex_d[ex_n] = SYNC[k] ? 3'd7 : 3'd0;
      ex_n++;
    end
    for (int i = 0; i < FL - 24; i++) begin
      push(3'd4);
      ex_d[ex_n] = 3'd4;
      ex_n++;
    end
    for (int i = 0; i < 8; i++) push(3'd4);
    idle(1); #1;
    chk(!in_frame, "R7 no capture from in-frame pattern", int'(in_frame), 0);
    idle(6);
    chk(rx_n == FL, "R7 exactly one frame", rx_n, FL);
    cmp_rx(FL, "R7 data");
    chk(rx_l[FL-1], "R7 tlast", int'(rx_l[FL-1]), 1);
  endtask

  task automatic t_b2b();
    rx_n = 0; ex_n = 0;
    clear_window();
    sync_thr = SCW'(corr(SYNC, 7, 0));
    send_word(SYNC, 3'd7, 3'd0);
    send_frame(1'b0);
    send_word(SYNC, 3'd7, 3'd0);
    idle(1); #1;
    chk(in_frame, "R8 sync right after frame", int'(in_frame), 1);
    send_frame(1'b0);
    idle(6);
    chk(rx_n == 2 * FL, "R8 two frames", rx_n, 2 * FL);
    cmp_rx(2 * FL, "R8 data");
    chk(rx_l[FL-1] && rx_l[2*FL-1] && !rx_l[FL], "R8 R5 tlast per frame",
        int'(rx_l[FL-1]), 1);
  endtask

  task automatic t_stall();
    logic [SW-1:0] held;
    rx_n = 0; ex_n = 0;
    clear_window();
    m_tready = 1'b0;
    sync_thr = SCW'(corr(SYNC, 7, 0));
    send_word(SYNC, 3'd7, 3'd0);
    send_frame(1'b0);
    idle(3); #1;
    held = m_tdata;
    chk(m_tvalid && rx_n == 0, "R9 valid held under stall", int'(m_tvalid), 1);
    idle(4); #1;
    chk(m_tvalid && m_tdata == held, "R9 data stable", int'(m_tdata), int'(held));
    chk(!ovf, "R10 no overflow when space", int'(ovf), 0);
    m_tready = 1'b1;
    idle(FL + 4);
    chk(rx_n == FL, "R9 no loss", rx_n, FL);
    cmp_rx(FL, "R9 order");
  endtask

  task automatic t_ovf();
    int lasts = 0;
    rx_n = 0; ex_n = 0;
    clear_window();
    m_tready = 1'b0;
    sync_thr = SCW'(corr(SYNC, 7, 0));
    send_word(SYNC, 3'd7, 3'd0);
    send_frame(1'b0);
    idle(1); #1;
    chk(!ovf, "R10 first frame fits", int'(ovf), 0);
    send_word(SYNC, 3'd7, 3'd0);
    send_frame(1'b0);
    idle(1); #1;
    chk(ovf, "R10 overflow raised", int'(ovf), 1);
    m_tready = 1'b1;
    idle(DP + 6);
    chk(rx_n == DP, "R10 only stored values out", rx_n, DP);
    cmp_rx(DP, "R10 survivors");
    for (int i = 0; i < DP; i++) if (rx_l[i]) lasts++;
    chk(lasts == 1, "R10 R5 dropped tlast", lasts, 1);
    chk(ovf, "R10 sticky", int'(ovf), 1);
  endtask

  initial begin
    #800000;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    in_valid = 1'b0;
    in_soft = '0;
    sync_thr = 9'd200;
    m_tready = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_threshold();
    t_suppress();
    t_b2b();
    t_stall();
    t_ovf();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule